// File: doc/BRIEF.md
# Video Test Pattern Generator

This block sits in a video pixel path and either forwards the incoming 4:4:4 10-bit YCrCb pixels or replaces them with a synthetic test image. Two patterns are available. The first is a cross-hatch: coloured lines on a black background. The second is a flat field in one colour. The colour of the lines or of the field comes from three 8-bit registers for Y, Cr and Cb. A software-side agent loads all three at once through a write strobe. Each 8-bit value is widened to 10 bits by appending two zero bits.

A raster tracker follows the incoming active-video flag and a start-of-frame marker to work out the column and row of every active pixel. It is a state machine with three states. `ST_VBLANK` waits for the first active run of a frame. `ST_HBLANK` is the gap between lines. `ST_ACTIVE` covers a run of active pixels. The named transitions are:
- `frame_begin` (ST_VBLANK to ST_ACTIVE on any active pixel)
- `line_begin` (ST_HBLANK to ST_ACTIVE)
- `line_end` (ST_ACTIVE to ST_HBLANK when the active flag drops before the last row)
- `frame_end` (ST_ACTIVE to ST_VBLANK when the last row ends)
- `frame_restart` (a start-of-frame marker seen in ST_HBLANK or ST_ACTIVE)

An output stage registers the chosen pixel together with a valid flag. A mode decode picks one of five sources: `MODE_BLANK`, `MODE_BLACK`, `MODE_PASS`, `MODE_HATCH` or `MODE_FIELD`.

Top module: `video_tpg`

## Requirements
- R1: After reset, `out_valid` is 0 and the outputs hold blanking (Y=64, Cb=Cr=512). The colour registers start at Y=A0h, Cr=80h, Cb=80h, so a reset-default field pixel comes out as Y=640, Cb=Cr=512.
- R2: Every output has exactly one cycle of latency. `out_valid` equals `in_de` of the previous cycle.
- R3: An input cycle with `in_de`=0 produces Y=64, Cb=Cr=512 whatever the control bits are.
- R4: With `in_de`=1 and `ctl_pix_en`=0, the output is black (Y=64, Cb=Cr=512) whatever `ctl_tp_en`, `ctl_field` and the input pixel are.
- R5: With `ctl_pix_en`=1 and `ctl_tp_en`=0, the input pixel appears unchanged on the outputs one cycle later.
- R6: With `ctl_pix_en`=1, `ctl_tp_en`=1 and `ctl_field`=1, every active pixel takes the colour register values, each shifted left by two bits.
- R7: With `ctl_pix_en`=1, `ctl_tp_en`=1 and `ctl_field`=0, a pixel takes the colour when its column or row is a multiple of 2^SPACING_LOG2, or is the last column (H_ACTIVE-1) or last row (V_ACTIVE-1). Every other pixel is black.
- R8: The column counts from 0 at the start of each active run. The row is 0 on a pixel flagged by `in_sof`, and it goes up by one at the end of each active run. After V_ACTIVE runs, the next active run is row 0 even without `in_sof`.
- R9: A cycle with `cfg_wr`=1 loads all three colour registers. The new colour applies from the next input pixel onward, and the pixel in the write cycle still uses the old colour.
- R10: While the test pattern is shown, the input pixel values have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_de | input | 1 | Input pixel is active video |
| in_sof | input | 1 | Marks the first active pixel of a frame (used only with in_de) |
| in_y | input | 10 | Input luma |
| in_cb | input | 10 | Input blue-difference chroma |
| in_cr | input | 10 | Input red-difference chroma |
| ctl_pix_en | input | 1 | Pixel data enable; 0 forces black |
| ctl_tp_en | input | 1 | Test pattern enable |
| ctl_field | input | 1 | 0 = cross-hatch, 1 = uniform field |
| cfg_wr | input | 1 | Load strobe for the colour registers |
| cfg_y | input | 8 | New luma colour |
| cfg_cb | input | 8 | New Cb colour |
| cfg_cr | input | 8 | New Cr colour |
| out_valid | output | 1 | Output pixel is active video |
| out_y | output | 10 | Output luma |
| out_cb | output | 10 | Output Cb |
| out_cr | output | 10 | Output Cr |

## Verification
Whole frames run on a small raster (20x12, hatch spacing 4). The control bits change at random from line to line, the input pixels are random, and colour writes land at random moments. This exercises all five output sources side by side.

Random input data under the pattern modes shows that the pattern ignores the input (R10), while pass-through mode copies it exactly. Colour writes that land in the middle of a line separate old-colour pixels from new-colour pixels (R9). The hatch frames hit both grid lines and the last column and row, which separates the spacing rule from the edge rule.

Directed frames cover three cases: a field drawn with the reset colours, a frame sent without a start marker, and a frame cut short by an early start marker. Together they separate the row-wrap path from the explicit-restart path.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int PIX_W = 10;
    localparam int COL_W = 8;

    localparam logic [COL_W-1:0] BLACK_Y8  = 8'd16;
    localparam logic [COL_W-1:0] CHROMA_Z8 = 8'd128;

    localparam logic [COL_W-1:0] RST_COL_Y  = 8'hA0;
    localparam logic [COL_W-1:0] RST_COL_CB = 8'h80;
    localparam logic [COL_W-1:0] RST_COL_CR = 8'h80;

    typedef enum logic [1:0] {
        ST_VBLANK = 2'd0,
        ST_HBLANK = 2'd1,
        ST_ACTIVE = 2'd2
    } raster_state_t;

    typedef enum logic [2:0] {
        MODE_BLANK = 3'd0,
        MODE_BLACK = 3'd1,
        MODE_PASS  = 3'd2,
        MODE_HATCH = 3'd3,
        MODE_FIELD = 3'd4
    } pix_mode_t;

    function automatic logic [PIX_W-1:0] widen(input logic [COL_W-1:0] c);
        return {c, {(PIX_W-COL_W){1'b0}}};
    endfunction

endpackage

// File: rtl/tpg_colour_regs.sv
module tpg_colour_regs
    import tpg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [COL_W-1:0] cfg_y,
    input  logic [COL_W-1:0] cfg_cb,
    input  logic [COL_W-1:0] cfg_cr,
    output logic [COL_W-1:0] col_y,
    output logic [COL_W-1:0] col_cb,
    output logic [COL_W-1:0] col_cr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_y  <= RST_COL_Y;
            col_cb <= RST_COL_CB;
            col_cr <= RST_COL_CR;
        end else if (cfg_wr) begin
            col_y  <= cfg_y;
            col_cb <= cfg_cb;
            col_cr <= cfg_cr;
        end
    end

    AST_COLOUR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (col_y == $past(cfg_y) && col_cb == $past(cfg_cb) && col_cr == $past(cfg_cr))); // R9

    AST_COLOUR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr |=> ($stable(col_y) && $stable(col_cb) && $stable(col_cr))); // R9

endmodule

// File: rtl/tpg_raster.sv
module tpg_raster
    import tpg_pkg::*;
#(
    parameter int H_ACTIVE     = 1920,
    parameter int V_ACTIVE     = 1080,
    parameter int SPACING_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_de,
    input  logic in_sof,
    output logic hatch_hit
);

    localparam int XW = $clog2(H_ACTIVE) + 1;
    localparam int YW = $clog2(V_ACTIVE) + 1;
    localparam logic [XW-1:0] X_LAST = XW'(H_ACTIVE - 1);
    localparam logic [YW-1:0] Y_LAST = YW'(V_ACTIVE - 1);

    raster_state_t state, state_nx;
    logic [XW-1:0] h_cnt, h_cnt_nx;
    logic [YW-1:0] v_cnt, v_cnt_nx;
    logic [XW-1:0] cur_x;
    logic [YW-1:0] cur_y;
    logic          restart;

    // State and counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_VBLANK;
            h_cnt <= '0;
            v_cnt <= '0;
        end else begin
            state <= state_nx;
            h_cnt <= h_cnt_nx;
            v_cnt <= v_cnt_nx;
        end
    end

    // Next state: frame_begin, line_begin, line_end, frame_end, frame_restart
    always_comb begin
        state_nx = state;
        h_cnt_nx = h_cnt;
        v_cnt_nx = v_cnt;
        unique case (state)
            ST_VBLANK: begin
                if (in_de) begin
                    state_nx = ST_ACTIVE;
                    h_cnt_nx = XW'(1);
                    v_cnt_nx = '0;
                end
            end
            ST_HBLANK: begin
                if (in_de) begin
                    state_nx = ST_ACTIVE;
                    h_cnt_nx = XW'(1);
                    if (in_sof) v_cnt_nx = '0;
                end
            end
            ST_ACTIVE: begin
                if (in_de) begin
                    if (in_sof) begin
                        h_cnt_nx = XW'(1);
                        v_cnt_nx = '0;
                    end else begin
                        h_cnt_nx = h_cnt + XW'(1);
                    end
                end else begin
                    h_cnt_nx = '0;
                    if (v_cnt == Y_LAST) begin
                        state_nx = ST_VBLANK;
                        v_cnt_nx = '0;
                    end else begin
                        state_nx = ST_HBLANK;
                        v_cnt_nx = v_cnt + YW'(1);
                    end
                end
            end
            default: begin
                state_nx = ST_VBLANK;
                h_cnt_nx = '0;
                v_cnt_nx = '0;
            end
        endcase
    end

    // Outputs: position of the current input pixel and hatch decision
    always_comb begin
        restart = in_sof || (state == ST_VBLANK);
        cur_x   = (state == ST_ACTIVE && !in_sof) ? h_cnt : '0;
        cur_y   = restart ? '0 : v_cnt;
        hatch_hit = (cur_x[SPACING_LOG2-1:0] == '0) ||
                    (cur_y[SPACING_LOG2-1:0] == '0) ||
                    (cur_x == X_LAST) ||
                    (cur_y == Y_LAST);
    end

    AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && !in_de && v_cnt != Y_LAST) |=>
        (state == ST_HBLANK && v_cnt == $past(v_cnt) + YW'(1) && h_cnt == '0)); // R8

    AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && !in_de && v_cnt == Y_LAST) |=>
        (state == ST_VBLANK && v_cnt == '0)); // R8

    AST_SOF_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
        (in_de && in_sof) |=> (state == ST_ACTIVE && v_cnt == '0 && h_cnt == XW'(1))); // R8

endmodule

// File: rtl/video_tpg.sv
module video_tpg
    import tpg_pkg::*;
#(
    parameter int H_ACTIVE     = 1920,
    parameter int V_ACTIVE     = 1080,
    parameter int SPACING_LOG2 = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_de,
    input  logic        in_sof,
    input  logic [9:0]  in_y,
    input  logic [9:0]  in_cb,
    input  logic [9:0]  in_cr,
    input  logic        ctl_pix_en,
    input  logic        ctl_tp_en,
    input  logic        ctl_field,
    input  logic        cfg_wr,
    input  logic [7:0]  cfg_y,
    input  logic [7:0]  cfg_cb,
    input  logic [7:0]  cfg_cr,
    output logic        out_valid,
    output logic [9:0]  out_y,
    output logic [9:0]  out_cb,
    output logic [9:0]  out_cr
);

    localparam logic [PIX_W-1:0] BLK_Y = widen(BLACK_Y8);
    localparam logic [PIX_W-1:0] BLK_C = widen(CHROMA_Z8);

    logic [COL_W-1:0] col_y, col_cb, col_cr;
    logic             hatch_hit;
    pix_mode_t        mode;
    logic [PIX_W-1:0] nx_y, nx_cb, nx_cr;

    tpg_colour_regs u_colour (
        .clk    (clk),
        .rst_n  (rst_n),
        .cfg_wr (cfg_wr),
        .cfg_y  (cfg_y),
        .cfg_cb (cfg_cb),
        .cfg_cr (cfg_cr),
        .col_y  (col_y),
        .col_cb (col_cb),
        .col_cr (col_cr)
    );

    tpg_raster #(
        .H_ACTIVE     (H_ACTIVE),
        .V_ACTIVE     (V_ACTIVE),
        .SPACING_LOG2 (SPACING_LOG2)
    ) u_raster (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_de     (in_de),
        .in_sof    (in_sof),
        .hatch_hit (hatch_hit)
    );

    // Source selection
    always_comb begin
        if (!in_de)           mode = MODE_BLANK;
        else if (!ctl_pix_en) mode = MODE_BLACK;
        else if (!ctl_tp_en)  mode = MODE_PASS;
        else if (ctl_field)   mode = MODE_FIELD;
        else                  mode = MODE_HATCH;
    end

    always_comb begin
        unique case (mode)
            MODE_PASS: begin
                nx_y = in_y; nx_cb = in_cb; nx_cr = in_cr;
            end
            MODE_FIELD: begin
                nx_y = widen(col_y); nx_cb = widen(col_cb); nx_cr = widen(col_cr);
            end
            MODE_HATCH: begin
                if (hatch_hit) begin
                    nx_y = widen(col_y); nx_cb = widen(col_cb); nx_cr = widen(col_cr);
                end else begin
                    nx_y = BLK_Y; nx_cb = BLK_C; nx_cr = BLK_C;
                end
            end
            default: begin
                nx_y = BLK_Y; nx_cb = BLK_C; nx_cr = BLK_C;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_y     <= BLK_Y;
            out_cb    <= BLK_C;
            out_cr    <= BLK_C;
        end else begin
            out_valid <= in_de;
            out_y     <= nx_y;
            out_cb    <= nx_cb;
            out_cr    <= nx_cr;
        end
    end

    AST_VALID_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (out_valid == $past(in_de))); // R2

    AST_BLANK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        !in_de |=> (out_y == 10'd64 && out_cb == 10'd512 && out_cr == 10'd512)); // R3

    AST_BLACK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_de && !ctl_pix_en) |=> (out_y == 10'd64 && out_cb == 10'd512 && out_cr == 10'd512)); // R4

    AST_PASS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_de && ctl_pix_en && !ctl_tp_en) |=>
        (out_y == $past(in_y) && out_cb == $past(in_cb) && out_cr == $past(in_cr))); // R5

    AST_FIELD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_de && ctl_pix_en && ctl_tp_en && ctl_field) |=>
        (out_y[1:0] == 2'b00 && out_y[9:2] == $past(col_y) && out_cr[9:2] == $past(col_cr))); // R6

endmodule

// File: tb/video_tpg_tb.sv
module video_tpg_tb;

    localparam int H = 20;
    localparam int V = 12;
    localparam int SL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_de = 1'b0, in_sof = 1'b0;
    logic [9:0] in_y = '0, in_cb = '0, in_cr = '0;
    logic       ctl_pix_en = 1'b0, ctl_tp_en = 1'b0, ctl_field = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_y = '0, cfg_cb = '0, cfg_cr = '0;
    logic       out_valid;
    logic [9:0] out_y, out_cb, out_cr;

    int errors = 0;
    int checks = 0;
    logic [7:0] sh_y = 8'hA0, sh_cb = 8'h80, sh_cr = 8'h80;

    always #2.5 clk = ~clk;

    video_tpg #(.H_ACTIVE(H), .V_ACTIVE(V), .SPACING_LOG2(SL)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_de(in_de), .in_sof(in_sof),
        .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .ctl_pix_en(ctl_pix_en), .ctl_tp_en(ctl_tp_en), .ctl_field(ctl_field),
        .cfg_wr(cfg_wr), .cfg_y(cfg_y), .cfg_cb(cfg_cb), .cfg_cr(cfg_cr),
        .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    function automatic bit on_grid(int x, int y);
        return (x % (1 << SL) == 0) || (y % (1 << SL) == 0) || (x == H-1) || (y == V-1);
    endfunction

    task automatic check(string tag, logic v, logic [9:0] ey, logic [9:0] ecb, logic [9:0] ecr, logic ev);
        checks++;
        if (out_valid !== ev || out_y !== ey || out_cb !== ecb || out_cr !== ecr) begin
            errors++;
            $display("FAIL %s: got v=%0b y=%0d cb=%0d cr=%0d expected v=%0b y=%0d cb=%0d cr=%0d",
                     tag, out_valid, out_y, out_cb, out_cr, v, ey, ecb, ecr);
        end
    endtask

    // One input cycle; x,y are the bench's own raster position (ignored when de=0)
    task automatic step(logic de, logic sof, int x, int y, logic pe, logic te, logic fs,
                        logic wr, string tag_over);
        logic [9:0] ey, ecb, ecr;
        string tag;
        @(negedge clk);
        in_de = de; in_sof = sof;
        in_y = 10'($urandom); in_cb = 10'($urandom); in_cr = 10'($urandom);
        ctl_pix_en = pe; ctl_tp_en = te; ctl_field = fs;
        cfg_wr = wr;
        cfg_y = 8'($urandom); cfg_cb = 8'($urandom); cfg_cr = 8'($urandom);
        if (!de) begin
            ey = 10'd64; ecb = 10'd512; ecr = 10'd512; tag = "R3 blank";
        end else if (!pe) begin
            ey = 10'd64; ecb = 10'd512; ecr = 10'd512; tag = "R4 black";
        end else if (!te) begin
            ey = in_y; ecb = in_cb; ecr = in_cr; tag = "R5 pass R2";
        end else if (fs || on_grid(x, y)) begin
            ey = {sh_y, 2'b00}; ecb = {sh_cb, 2'b00}; ecr = {sh_cr, 2'b00};
            tag = fs ? "R6 field R10 R9" : "R7 hatch line R8 R10 R9";
        end else begin
            ey = 10'd64; ecb = 10'd512; ecr = 10'd512; tag = "R7 hatch background R8";
        end
        if (tag_over != "") tag = tag_over;
        if (wr) begin
            sh_y = cfg_y; sh_cb = cfg_cb; sh_cr = cfg_cr;
        end
        @(posedge clk);
        #1;
        check(tag, de, ey, ecb, ecr, de);
    endtask

    // Drive rows [0, nrows) of a frame; controls random per line unless fixed
    task automatic frame(bit with_sof, int nrows, bit fixed, logic pe, logic te, logic fs, bit wr_en, string tag);
        for (int yy = 0; yy < nrows; yy++) begin
            logic lp, lt, lf;
            lp = fixed ? pe : ($urandom_range(0, 7) != 0);
            lt = fixed ? te : 1'($urandom);
            lf = fixed ? fs : 1'($urandom);
            for (int xx = 0; xx < H; xx++) begin
                logic w;
                w = wr_en && ($urandom_range(0, 15) == 0);
                step(1'b1, with_sof && xx == 0 && yy == 0, xx, yy, lp, lt, lf, w, tag);
            end
            for (int b = 0; b < 3; b++) step(1'b0, 1'b0, 0, 0, 1'($urandom), 1'($urandom), 1'($urandom), 1'b0, "");
        end
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd7197));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", 1'b0, 10'd64, 10'd512, 10'd512, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: field from reset colours, no writes
        frame(1'b1, V, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, "R1 reset colour field R6");
        // R7: hatch from reset colours
        frame(1'b1, V, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "");
        // R8: frame without start marker restarts at row 0 after V rows
        frame(1'b0, V, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "");
        // R8: short frame then early start marker
        frame(1'b1, 5, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "");
        frame(1'b1, V, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "");
        // R4: black despite pattern enabled
        frame(1'b1, 2, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "");
        // Random mix with colour writes
        for (int f = 0; f < 12; f++) frame(1'b1, V, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "");
        step(1'b0, 1'b0, 0, 0, 1'b1, 1'b1, 1'b1, 1'b0, "");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule